// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns a stream of run-length tokens from an infrared receiver front end into 32-bit remote-control codes. Each token is one byte. Bit 7 gives the line level, where 1 means carrier present (a mark) and 0 means idle (a space). Bits 6:0 give the run length in samples, minus one. A separate packet-end strobe tells the decoder that the front end has seen the line go quiet.

The decoder works through the frame in order. First it finds the long leader mark, then the leader space. After that it measures 32 mark/space pairs. A short space is a 0 and a long space is a 1, and the bits are collected least significant bit first. When the frame finishes, the decoder gives a single result strobe carrying the code and a flag. The flag is set only when the command byte and its inverted copy agree. A timing violation gives an all-ones error code instead. A frame cut short by packet end gives the partial code, marked not valid.

Top module: `nec_frame_decoder`

## Requirements
- R1: A token's duration is its bits 6:0 plus one. Bit 7 = 1 is a mark and bit 7 = 0 is a space. Back-to-back tokens of the same level add into one run.
- R2: At the start of each leader search the mark accumulator is preloaded with 80. The leader mark is accepted when a space token arrives while the accumulated mark exceeds 80. Otherwise the accumulator clears and the search goes on. The accepting space token begins the leader space.
- R3: The leader space is accepted when a mark token arrives while the accumulated space exceeds 40 samples. Otherwise the space accumulator clears and the search for a leader space goes on.
- R4: A data mark that accumulates more than 26 samples before its space begins ends the frame with an error. A mark of exactly 26 samples is legal.
- R5: A data space is closed by the next mark token. If the space is longer than 53 samples, the frame ends with an error. If it is longer than 26 samples, the bit is 1. Otherwise the bit is 0.
- R6: Bit k of the frame is stored in code bit k. The 32nd bit is closed by a trailing mark token, and the result strobe rises in the cycle after that token.
- R7: An error result carries code 0xFFFFFFFF with the valid flag low.
- R8: The valid flag of a complete frame is high exactly when code[23:16] XOR code[31:24] equals 0xFF. Bits 15:0 are not examined.
- R9: A packet-end strobe while the decoder is still looking for the leader mark or leader space produces an error result.
- R10: A packet-end strobe during data produces a result that carries the bits decoded so far (the rest zero), with the valid flag low.
- R11: After a completed or failed frame, tokens are ignored and produce no result until packet end. That packet end itself produces no result, and leader search then restarts.
- R12: When a token and a packet end fall in the same cycle, the token is handled first. If that token finishes the frame, exactly one result is produced and leader search restarts at once.
- R13: After reset the strobe, code and flag are all zero. The code and flag hold their value between strobes, and each strobe lasts one cycle per result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_vld | input | 1 | Token present this cycle |
| tok_data | input | 8 | Level (bit 7) and length minus one (bits 6:0) |
| pkt_end | input | 1 | Packet-end strobe from the front end |
| res_vld | output | 1 | One-cycle result strobe |
| res_code | output | 32 | Decoded code, or all ones on error |
| res_ok | output | 1 | Command byte matches its inverse |

## Verification
The collision that matters is a frame-closing token and a packet-end strobe arriving in the same cycle. The decoder could then report the frame twice, report it once as a partial code, or stay stuck waiting for a later packet end. The bench drives the trailing mark of a full frame together with packet end and expects exactly one result that is valid and carries the full code. It then starts a new frame at once, without another packet end, and expects that frame to decode as well. The scoreboard flags any extra or missing strobe.

// File: rtl/nec_pkg.sv
package nec_pkg;
    localparam int NEC_ACC_W = 12;
    localparam int NEC_NBITS = 32;
    localparam int NEC_CNT_W = $clog2(NEC_NBITS + 1);

    typedef enum logic [2:0] {
        ST_LEAD_MARK,
        ST_LEAD_SPACE,
        ST_BIT_MARK,
        ST_BIT_SPACE,
        ST_DRAIN
    } nec_state_e;

    typedef struct packed {
        nec_state_e              st;
        logic [NEC_ACC_W-1:0]    acc;
        logic [NEC_NBITS-1:0]    code;
        logic [NEC_CNT_W-1:0]    cnt;
        logic                    vld;
        logic [NEC_NBITS-1:0]    res;
        logic                    ok;
    } nec_regs_t;
endpackage

// File: rtl/nec_tok_unpack.sv
module nec_tok_unpack #(
    parameter int TOK_W = 8
) (
    input  logic [TOK_W-1:0] tok,
    output logic             lvl,
    output logic [TOK_W-1:0] dur
);
    localparam int LEN_W = TOK_W - 1;

    assign lvl = tok[TOK_W-1];
    assign dur = {1'b0, tok[LEN_W-1:0]} + TOK_W'(1);
endmodule

// File: rtl/nec_dur_cmp.sv
module nec_dur_cmp #(
    parameter int ACC_W = 12,
    parameter int LIM   = 26
) (
    input  logic [ACC_W-1:0] run_len,
    output logic             over
);
    assign over = run_len > ACC_W'(LIM);
endmodule

// File: rtl/nec_code_check.sv
module nec_code_check #(
    parameter int NBITS = 32
) (
    input  logic [NBITS-1:0] code,
    output logic             ok
);
    assign ok = ((code[NBITS-9:NBITS-16] ^ code[NBITS-1:NBITS-8]) == 8'hFF);
endmodule

// File: rtl/nec_frame_decoder.sv
module nec_frame_decoder
    import nec_pkg::*;
#(
    parameter int TOK_W      = 8,
    parameter int PRELOAD    = 80,
    parameter int LEAD_MARK  = 80,
    parameter int LEAD_SPACE = 40,
    parameter int MARK_MAX   = 26,
    parameter int SPACE_MID  = 26,
    parameter int SPACE_MAX  = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_vld,
    input  logic [TOK_W-1:0]     tok_data,
    input  logic                 pkt_end,
    output logic                 res_vld,
    output logic [NEC_NBITS-1:0] res_code,
    output logic                 res_ok
);
    localparam int ACC_W = NEC_ACC_W;
    localparam int IDX_W = $clog2(NEC_NBITS);
    localparam int NLIM  = 5;
    localparam int LIMS [NLIM] = '{LEAD_MARK, LEAD_SPACE, MARK_MAX, SPACE_MID, SPACE_MAX};

    nec_regs_t state_d, state_q;

    logic             tok_lvl;
    logic [TOK_W-1:0] tok_dur;
    logic [NLIM-1:0]  over;
    logic             code_ok;

    nec_tok_unpack #(.TOK_W(TOK_W)) u_unpack (
        .tok (tok_data),
        .lvl (tok_lvl),
        .dur (tok_dur)
    );

    for (genvar g = 0; g < NLIM; g++) begin : g_cmp
        nec_dur_cmp #(.ACC_W(ACC_W), .LIM(LIMS[g])) u_cmp (
            .run_len (state_q.acc),
            .over    (over[g])
        );
    end

    nec_code_check #(.NBITS(NEC_NBITS)) u_check (
        .code (state_d.code),
        .ok   (code_ok)
    );

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [TOK_W-1:0] d);
        logic [ACC_W:0] s;
        s = {1'b0, a} + (ACC_W+1)'(d);
        return s[ACC_W] ? '1 : s[ACC_W-1:0];
    endfunction

    logic [ACC_W-1:0] dur_ext;
    assign dur_ext = ACC_W'(tok_dur);

    always_comb begin
        logic fin, fin_err, fin_done;
        state_d     = state_q;
        state_d.vld = 1'b0;
        fin_err     = 1'b0;
        fin_done    = 1'b0;
        if (tok_vld) begin
            unique case (state_q.st)
                ST_LEAD_MARK: begin
                    if (tok_lvl)            state_d.acc = sat_add(state_q.acc, tok_dur);
                    else if (over[0]) begin
                        state_d.st  = ST_LEAD_SPACE;
                        state_d.acc = dur_ext;
                    end else                state_d.acc = '0;
                end
                ST_LEAD_SPACE: begin
                    if (!tok_lvl)           state_d.acc = sat_add(state_q.acc, tok_dur);
                    else if (over[1]) begin
                        state_d.st   = ST_BIT_MARK;
                        state_d.acc  = dur_ext;
                        state_d.code = '0;
                        state_d.cnt  = '0;
                    end else                state_d.acc = '0;
                end
                ST_BIT_MARK: begin
                    if (tok_lvl)            state_d.acc = sat_add(state_q.acc, tok_dur);
                    else if (over[2])       fin_err = 1'b1;
                    else begin
                        state_d.st  = ST_BIT_SPACE;
                        state_d.acc = dur_ext;
                    end
                end
                ST_BIT_SPACE: begin
                    if (!tok_lvl)           state_d.acc = sat_add(state_q.acc, tok_dur);
                    else if (over[4])       fin_err = 1'b1;
                    else begin
                        state_d.code[state_q.cnt[IDX_W-1:0]] = over[3];
                        state_d.cnt = state_q.cnt + 1'b1;
                        if (state_d.cnt == NEC_CNT_W'(NEC_NBITS)) fin_done = 1'b1;
                        else begin
                            state_d.st  = ST_BIT_MARK;
                            state_d.acc = dur_ext;
                        end
                    end
                end
                default: ;
            endcase
        end
        fin = fin_err | fin_done;
        if (fin) begin
            state_d.st  = ST_DRAIN;
            state_d.vld = 1'b1;
            state_d.res = fin_err ? '1 : state_d.code;
            state_d.ok  = fin_done & code_ok;
        end
        if (pkt_end) begin
            if (!fin) begin
                unique case (state_d.st)
                    ST_LEAD_MARK, ST_LEAD_SPACE: begin
                        state_d.vld = 1'b1;
                        state_d.res = '1;
                        state_d.ok  = 1'b0;
                    end
                    ST_BIT_MARK, ST_BIT_SPACE: begin
                        state_d.vld = 1'b1;
                        state_d.res = state_d.code;
                        state_d.ok  = 1'b0;
                    end
                    default: ;
                endcase
            end
            state_d.st  = ST_LEAD_MARK;
            state_d.acc = ACC_W'(PRELOAD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.st   <= ST_LEAD_MARK;
            state_q.acc  <= ACC_W'(PRELOAD);
        end else begin
            state_q <= state_d;
        end
    end

    assign res_vld  = state_q.vld;
    assign res_code = state_q.res;
    assign res_ok   = state_q.ok;
endmodule

// File: rtl/nec_frame_checker.sv
module nec_frame_checker #(
    parameter int NBITS = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_vld,
    input logic [NBITS-1:0] res_code,
    input logic             res_ok,
    input logic             in_drain,
    input logic [CNT_W-1:0] bit_cnt
);
    p_ok_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && res_ok |-> ((res_code[23:16] ^ res_code[31:24]) == 8'hFF));

    p_err_not_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld && (res_code == '1) |-> !res_ok);

    p_drain_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_drain |=> !res_vld);

    p_hold_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> $stable(res_code) && $stable(res_ok));

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(NBITS));
endmodule

bind nec_frame_decoder nec_frame_checker #(
    .NBITS (nec_pkg::NEC_NBITS),
    .CNT_W (nec_pkg::NEC_CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_vld  (res_vld),
    .res_code (res_code),
    .res_ok   (res_ok),
    .in_drain (state_q.st == nec_pkg::ST_DRAIN),
    .bit_cnt  (state_q.cnt)
);

// File: tb/nec_frame_decoder_tb_top.sv
module nec_frame_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_vld = 1'b0;
    logic [7:0]  tok_data = '0;
    logic        pkt_end = 1'b0;
    logic        res_vld;
    logic [31:0] res_code;
    logic        res_ok;

    int total = 0;
    int bad   = 0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    nec_frame_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_data(tok_data),
        .pkt_end(pkt_end), .res_vld(res_vld), .res_code(res_code), .res_ok(res_ok)
    );

    task automatic expect_res(input logic [31:0] c, input logic ok, input string tag);
        exp_q.push_back({ok, c});
        tag_q.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected result: code=%h ok=%0d expected none", res_code, res_ok);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({res_ok, res_code} !== e) begin
                    bad++;
                    $display("FAIL %s: code=%h ok=%0d expected code=%h ok=%0d",
                             t, res_code, res_ok, e[31:0], e[32]);
                end
            end
        end
    end

    task automatic drive(input logic v, input logic [7:0] d, input logic pe);
        @(negedge clk);
        tok_vld = v; tok_data = d; pkt_end = pe;
    endtask
    task automatic tok(input logic lv, input int n);
        drive(1'b1, {lv, 7'(n - 1)}, 1'b0);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0);
    endtask
    task automatic pend();
        drive(1'b0, 8'h00, 1'b1);
        idle(4);
    endtask
    task automatic head();
        tok(1'b1, 100);
        tok(1'b0, 105);
    endtask
    task automatic bits(input logic [31:0] c, input int from, input int to);
        for (int i = from; i < to; i++) begin
            tok(1'b1, 13);
            tok(1'b0, c[i] ? 39 : 13);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (res_vld !== 1'b0 || res_code !== 32'h0 || res_ok !== 1'b0) begin
            bad++;
            $display("FAIL R13 reset: vld=%0d code=%h ok=%0d expected 0/0/0", res_vld, res_code, res_ok);
        end
        rst_n = 1'b1;
        idle(2);

        // R9: packet end with no leader at all
        expect_res(32'hFFFFFFFF, 1'b0, "R9 idle packet end");
        pend();

        // R1 R6 R8 R11: clean frame, trailing packet end silent
        expect_res(32'hE51A00FF, 1'b1, "R6 valid frame");
        head(); bits(32'hE51A00FF, 0, 32); tok(1'b1, 13); idle(3); pend();

        // R8: bad inverse
        expect_res(32'h12345678, 1'b0, "R8 inverse mismatch");
        head(); bits(32'h12345678, 0, 32); tok(1'b1, 13); pend();

        // R8: address bytes ignored
        expect_res(32'hF00FAB01, 1'b1, "R8 address unchecked");
        head(); bits(32'hF00FAB01, 0, 32); tok(1'b1, 13); pend();

        // R4 R5: boundary spaces 26->0, 27->1, 53->1, mark of 26 accepted
        expect_res(32'h6D9200F6, 1'b1, "R5 space boundaries");
        head();
        tok(1'b1, 13); tok(1'b0, 26);
        tok(1'b1, 13); tok(1'b0, 27);
        tok(1'b1, 26); tok(1'b0, 53);
        bits(32'h6D9200F6, 3, 32); tok(1'b1, 13); pend();

        // R5 R7 R11: space of 54 errors, later full frame ignored
        expect_res(32'hFFFFFFFF, 1'b0, "R5 space too long");
        head(); tok(1'b1, 13); tok(1'b0, 54); tok(1'b1, 13);
        head(); bits(32'hE51A00FF, 0, 32); tok(1'b1, 13);
        pend();

        // R4: mark of 27
        expect_res(32'hFFFFFFFF, 1'b0, "R4 mark too long");
        head(); tok(1'b1, 27); tok(1'b0, 13); pend();

        // R1 R4: split mark 14+13 sums to 27
        expect_res(32'hFFFFFFFF, 1'b0, "R1 split mark summed");
        head(); tok(1'b1, 14); tok(1'b1, 13); tok(1'b0, 13); pend();

        // R3: leader space of 40 rejected, then packet end
        expect_res(32'hFFFFFFFF, 1'b0, "R3 short leader space");
        tok(1'b1, 100); tok(1'b0, 40); tok(1'b1, 13); pend();

        // R1 R3: leader space 20+21 accepted
        expect_res(32'hE51A00FF, 1'b1, "R3 split leader space");
        tok(1'b1, 100); tok(1'b0, 20); tok(1'b0, 21);
        bits(32'hE51A00FF, 0, 32); tok(1'b1, 13); pend();

        // R2: preload alone lets a 1-sample mark pass
        expect_res(32'h00FF00FF, 1'b1, "R2 preload");
        tok(1'b1, 1); tok(1'b0, 105);
        bits(32'h00FF00FF, 0, 32); tok(1'b1, 13); pend();

        // R2: cleared accumulator needs a real mark above 80
        expect_res(32'h7F80CC33, 1'b1, "R2 cleared accumulator");
        tok(1'b0, 50); tok(1'b1, 50); tok(1'b0, 105); tok(1'b1, 90); tok(1'b0, 105);
        bits(32'h7F80CC33, 0, 32); tok(1'b1, 13); pend();

        // R10: partial frame of 8 bits
        expect_res(32'h000000A5, 1'b0, "R10 partial code");
        head(); bits(32'h000000A5, 0, 8); tok(1'b1, 13); pend();

        // R12: final token and packet end together, then immediate new frame
        expect_res(32'hE51A00FF, 1'b1, "R12 collide frame");
        head(); bits(32'hE51A00FF, 0, 32);
        drive(1'b1, {1'b1, 7'd12}, 1'b1);
        expect_res(32'h00FF00FF, 1'b1, "R12 next frame");
        head(); bits(32'h00FF00FF, 0, 32); tok(1'b1, 13); pend();

        idle(10);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R13 missing results: actual=%0d pending expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule